// File: doc/BRIEF.md
# Pulse-Averaged Beam Position and Phase Engine

This block sits behind the downconverters of a two-plate beam position monitor. During each acquisition window it takes decimated I/Q samples from both plates and from the RF reference channel. For every accepted sample it forms an approximate magnitude per plate and the cross product of the plate sum with the conjugate of the reference. These quantities are accumulated over the whole window. When the window closes, two sequential dividers and a vectoring rotator turn the sums into one result set for the beam pulse: position as a difference-over-sum ratio, mean intensity, and phase relative to the reference.

A window opens when `win_i` is high while the block is idle, and it closes when `win_i` falls. Samples that arrive while the results are being computed are not used. A one-cycle `done_o` pulse marks a new result set, which then stays on the outputs until the next pulse. When waveform mode is on, every accepted sample's plate magnitudes are also streamed out one clock later, so that selected monitors can deliver full pulse waveforms. Plate magnitude is approximated as max(|I|,|Q|) + floor(min(|I|,|Q|)/2), which avoids a square root. The sample count limit per window is 2^CW − 1.

Top module: `pulse_pos_phase_avg`

## Requirements
- R1: While reset is held and right after it is released, `done_o`, `wave_vld_o` and `pos_ok_o` are low, and `pos_o`, `inten_o` and `phase_o` are zero.
- R2: When `wave_en_i` is high and a sample is accepted (`win_i` and `smp_vld_i` both high, block not computing), `wave_vld_o` is high one clock later, and `wave_a_o` / `wave_b_o` carry max(|I|,|Q|) + floor(min(|I|,|Q|)/2) for plate A and for plate B.
- R3: While `wave_en_i` is low, `wave_vld_o` stays low.
- R4: `inten_o` equals floor((ΣA+ΣB)/N), where ΣA and ΣB are the window sums of the plate magnitudes and N is the number of accepted samples. It is 0 when N is 0.
- R5: `pos_o` is signed and equals (ΣA−ΣB)·2^FRAC/(ΣA+ΣB), truncated toward zero. +2^FRAC means that all signal is on plate A.
- R6: `pos_ok_o` is 1 exactly when ΣA+ΣB is nonzero. When it is 0, `pos_o` is 0.
- R7: `phase_o` is the angle of Σ(a+b)·conj(r) over the window. It is unsigned, with 2^16 units per full turn, measured counterclockwise from the +I axis, and it lies within ±12 units of the exact angle.
- R8: After `win_i` falls, `done_o` pulses high for exactly one cycle. The result outputs change only in that cycle.
- R9: Samples with `smp_vld_i` low inside a window add nothing to the sums or to N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_i | input | 1 | Acquisition window, high while the pulse is present |
| smp_vld_i | input | 1 | Decimated sample strobe |
| wave_en_i | input | 1 | Waveform streaming enable |
| a_re_i | input | DW | Plate A in-phase sample, signed |
| a_im_i | input | DW | Plate A quadrature sample, signed |
| b_re_i | input | DW | Plate B in-phase sample, signed |
| b_im_i | input | DW | Plate B quadrature sample, signed |
| r_re_i | input | DW | Reference in-phase sample, signed |
| r_im_i | input | DW | Reference quadrature sample, signed |
| done_o | output | 1 | One-cycle pulse: new result set |
| pos_o | output | FRAC+2 | Signed difference-over-sum position |
| pos_ok_o | output | 1 | Position valid (sum nonzero) |
| inten_o | output | DW+2 | Mean summed plate magnitude |
| phase_o | output | 16 | Phase relative to the reference |
| wave_vld_o | output | 1 | Streamed sample valid |
| wave_a_o | output | DW+1 | Streamed plate A magnitude |
| wave_b_o | output | DW+1 | Streamed plate B magnitude |

## Verification
The cases that are hardest to reach from the ports are the degenerate windows. One has samples but zero plate signal, so the position divider would see a zero divisor. The other has its window open but no valid strobe, so the intensity divisor is zero. The bench drives both on purpose, next to windows with gapped strobes. The magnitude path is swept over a near-exhaustive grid of I/Q pairs that includes the most negative input, spread over many back-to-back windows. The phase path is swept over sixteen angles that cover all four quadrants and the wrap at half a turn.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int PHW = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_CALC = 2'd2
    } st_e;

    // arctan(2^-i) in units of 2^PHW per turn
    function automatic logic [PHW-1:0] atan_step(input int i);
        case (i)
            0:  return 16'd8192;
            1:  return 16'd4836;
            2:  return 16'd2555;
            3:  return 16'd1297;
            4:  return 16'd651;
            5:  return 16'd326;
            6:  return 16'd163;
            7:  return 16'd81;
            8:  return 16'd41;
            9:  return 16'd20;
            10: return 16'd10;
            11: return 16'd5;
            12: return 16'd3;
            13: return 16'd1;
            14: return 16'd1;
            default: return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/pa_mag.sv
module pa_mag #(
    parameter int DW = 12
) (
    input  logic signed [DW-1:0] i_i,
    input  logic signed [DW-1:0] q_i,
    output logic        [DW:0]   mag_o
);
    logic [DW:0] ext_i, ext_q, abs_i, abs_q, hi, lo;

    always_comb begin
        ext_i = {i_i[DW-1], i_i};
        ext_q = {q_i[DW-1], q_i};
        abs_i = ext_i[DW] ? (~ext_i + 1'b1) : ext_i;
        abs_q = ext_q[DW] ? (~ext_q + 1'b1) : ext_q;
        hi    = (abs_i >= abs_q) ? abs_i : abs_q;
        lo    = (abs_i >= abs_q) ? abs_q : abs_i;
        mag_o = hi + (lo >> 1);
    end
endmodule

// File: rtl/pa_seqdiv.sv
module pa_seqdiv #(
    parameter int NW  = 16,
    parameter int DNW = 8,
    parameter int QW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NW-1:0]  num,
    input  logic [DNW-1:0] den,
    output logic           done_o,
    output logic [QW-1:0]  quo_o
);
    localparam int KW = $clog2(NW + 1);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [KW-1:0]  k;
        logic [NW-1:0]  n;
        logic [DNW-1:0] d;
        logic [DNW-1:0] r;
    } dv_t;

    dv_t dv_q, dv_d;
    logic [DNW:0] trial;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        trial     = {dv_q.r, dv_q.n[NW-1]};
        if (start) begin
            dv_d.busy = 1'b1;
            dv_d.k    = '0;
            dv_d.n    = num;
            dv_d.d    = den;
            dv_d.r    = '0;
        end else if (dv_q.busy) begin
            if (trial >= {1'b0, dv_q.d}) begin
                dv_d.r = DNW'(trial - {1'b0, dv_q.d});
                dv_d.n = {dv_q.n[NW-2:0], 1'b1};
            end else begin
                dv_d.r = trial[DNW-1:0];
                dv_d.n = {dv_q.n[NW-2:0], 1'b0};
            end
            dv_d.k = dv_q.k + 1'b1;
            if (dv_q.k == KW'(NW - 1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done_o = dv_q.done;
    assign quo_o  = dv_q.n[QW-1:0];

    // R5: a finished division leaves a remainder below the divisor
    p_rem_lt_den_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_q.done && dv_q.d != '0) |-> (dv_q.r < dv_q.d));

    // R8: completion is never reported while still iterating
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.done |-> !dv_q.busy);
endmodule

// File: rtl/pa_cordic.sv
module pa_cordic
    import pa_pkg::*;
#(
    parameter int XW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    output logic                 done_o,
    output logic [PHW-1:0]       ang_o
);
    localparam int IW   = XW + 2;
    localparam int ITER = PHW;
    localparam int KW   = $clog2(ITER) + 1;

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [KW-1:0]  k;
        logic [IW-1:0]  x;
        logic [IW-1:0]  y;
        logic [PHW-1:0] z;
    } cr_t;

    cr_t cr_q, cr_d;
    logic signed [IW-1:0] xs, ys, xsh, ysh, xe, ye;

    always_comb begin
        cr_d      = cr_q;
        cr_d.done = 1'b0;
        xs  = cr_q.x;
        ys  = cr_q.y;
        xsh = xs >>> cr_q.k;
        ysh = ys >>> cr_q.k;
        xe  = IW'(x_i);
        ye  = IW'(y_i);
        if (start) begin
            cr_d.busy = 1'b1;
            cr_d.k    = '0;
            if (xe[IW-1]) begin
                cr_d.x = -xe;
                cr_d.y = -ye;
                cr_d.z = {1'b1, {(PHW-1){1'b0}}};
            end else begin
                cr_d.x = xe;
                cr_d.y = ye;
                cr_d.z = '0;
            end
        end else if (cr_q.busy) begin
            if (!ys[IW-1]) begin
                cr_d.x = xs + ysh;
                cr_d.y = ys - xsh;
                cr_d.z = cr_q.z + atan_step(int'(cr_q.k));
            end else begin
                cr_d.x = xs - ysh;
                cr_d.y = ys + xsh;
                cr_d.z = cr_q.z - atan_step(int'(cr_q.k));
            end
            cr_d.k = cr_q.k + 1'b1;
            if (cr_q.k == KW'(ITER - 1)) begin
                cr_d.busy = 1'b0;
                cr_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign done_o = cr_q.done;
    assign ang_o  = cr_q.z;

    // R7: after the half-turn pre-rotation the vector stays in the right half plane
    p_x_nonneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cr_q.busy |-> !cr_q.x[IW-1]);
endmodule

// File: rtl/pulse_pos_phase_avg.sv
module pulse_pos_phase_avg
    import pa_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CW   = 16,
    parameter int FRAC = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   win_i,
    input  logic                   smp_vld_i,
    input  logic                   wave_en_i,
    input  logic signed [DW-1:0]   a_re_i,
    input  logic signed [DW-1:0]   a_im_i,
    input  logic signed [DW-1:0]   b_re_i,
    input  logic signed [DW-1:0]   b_im_i,
    input  logic signed [DW-1:0]   r_re_i,
    input  logic signed [DW-1:0]   r_im_i,
    output logic                   done_o,
    output logic signed [FRAC+1:0] pos_o,
    output logic                   pos_ok_o,
    output logic [DW+1:0]          inten_o,
    output logic [PHW-1:0]         phase_o,
    output logic                   wave_vld_o,
    output logic [DW:0]            wave_a_o,
    output logic [DW:0]            wave_b_o
);
    localparam int MAGW = DW + 1;
    localparam int SW   = MAGW + CW;
    localparam int TW   = SW + 1;
    localparam int XPW  = 2 * DW + 2;
    localparam int XW   = XPW + CW;
    localparam int PNW  = SW + FRAC;

    typedef struct packed {
        st_e             st;
        logic [SW-1:0]   sa;
        logic [SW-1:0]   sb;
        logic [CW-1:0]   n;
        logic [XW-1:0]   ax;
        logic [XW-1:0]   ay;
        logic            go;
        logic            pd;
        logic            id;
        logic            cd;
        logic            done;
        logic [FRAC+1:0] pos;
        logic            pos_ok;
        logic [MAGW:0]   inten;
        logic [PHW-1:0]  phs;
        logic            wv;
        logic [MAGW-1:0] wa;
        logic [MAGW-1:0] wb;
    } st_t;

    st_t st_q, st_d;

    logic [MAGW-1:0]        mag_a, mag_b;
    logic signed [DW:0]     s_re, s_im;
    logic signed [XPW-1:0]  cx, cy;
    logic                   take;
    logic [TW-1:0]          tot;
    logic                   neg;
    logic [SW-1:0]          dif;
    logic [PNW-1:0]         pnum;
    logic [FRAC:0]          pquo;
    logic [MAGW:0]          iquo;
    logic [FRAC+1:0]        pext;
    logic                   pdone, idone, cdone;
    logic [PHW-1:0]         cang;

    pa_mag #(.DW(DW)) u_mag_a (.i_i(a_re_i), .q_i(a_im_i), .mag_o(mag_a));
    pa_mag #(.DW(DW)) u_mag_b (.i_i(b_re_i), .q_i(b_im_i), .mag_o(mag_b));

    // per-sample cross product of plate sum with conjugate reference
    always_comb begin
        s_re = {a_re_i[DW-1], a_re_i} + {b_re_i[DW-1], b_re_i};
        s_im = {a_im_i[DW-1], a_im_i} + {b_im_i[DW-1], b_im_i};
        cx   = XPW'(s_re) * XPW'(r_re_i) + XPW'(s_im) * XPW'(r_im_i);
        cy   = XPW'(s_im) * XPW'(r_re_i) - XPW'(s_re) * XPW'(r_im_i);
    end

    // operands of the end-of-window engines
    always_comb begin
        tot  = {1'b0, st_q.sa} + {1'b0, st_q.sb};
        neg  = st_q.sa < st_q.sb;
        dif  = neg ? (st_q.sb - st_q.sa) : (st_q.sa - st_q.sb);
        pnum = {dif, {FRAC{1'b0}}};
    end

    pa_seqdiv #(.NW(PNW), .DNW(TW), .QW(FRAC + 1)) u_div_pos (
        .clk(clk), .rst_n(rst_n), .start(st_q.go),
        .num(pnum), .den(tot), .done_o(pdone), .quo_o(pquo)
    );

    pa_seqdiv #(.NW(TW), .DNW(CW), .QW(MAGW + 1)) u_div_int (
        .clk(clk), .rst_n(rst_n), .start(st_q.go),
        .num(tot), .den(st_q.n), .done_o(idone), .quo_o(iquo)
    );

    pa_cordic #(.XW(XW)) u_cordic (
        .clk(clk), .rst_n(rst_n), .start(st_q.go),
        .x_i(st_q.ax), .y_i(st_q.ay), .done_o(cdone), .ang_o(cang)
    );

    always_comb begin
        st_d      = st_q;
        st_d.go   = 1'b0;
        st_d.done = 1'b0;
        st_d.wv   = 1'b0;
        pext      = {1'b0, pquo};
        take      = win_i && smp_vld_i && (st_q.st != ST_CALC);

        if (st_q.st == ST_IDLE) begin
            st_d.sa = '0;
            st_d.sb = '0;
            st_d.n  = '0;
            st_d.ax = '0;
            st_d.ay = '0;
        end
        if (take) begin
            st_d.sa = st_d.sa + SW'(mag_a);
            st_d.sb = st_d.sb + SW'(mag_b);
            st_d.n  = st_d.n + 1'b1;
            st_d.ax = st_d.ax + XW'(cx);
            st_d.ay = st_d.ay + XW'(cy);
            st_d.wv = wave_en_i;
            st_d.wa = mag_a;
            st_d.wb = mag_b;
        end

        case (st_q.st)
            ST_IDLE: if (win_i) st_d.st = ST_ACC;
            ST_ACC: begin
                if (!win_i) begin
                    st_d.st = ST_CALC;
                    st_d.go = 1'b1;
                    st_d.pd = 1'b0;
                    st_d.id = 1'b0;
                    st_d.cd = 1'b0;
                end
            end
            ST_CALC: begin
                st_d.pd = st_q.pd | pdone;
                st_d.id = st_q.id | idone;
                st_d.cd = st_q.cd | cdone;
                if (st_d.pd && st_d.id && st_d.cd) begin
                    if (tot == '0) begin
                        st_d.pos    = '0;
                        st_d.pos_ok = 1'b0;
                    end else begin
                        st_d.pos    = neg ? (~pext + 1'b1) : pext;
                        st_d.pos_ok = 1'b1;
                    end
                    st_d.inten = (st_q.n == '0) ? '0 : iquo;
                    st_d.phs   = cang;
                    st_d.done  = 1'b1;
                    st_d.st    = ST_IDLE;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o     = st_q.done;
    assign pos_o      = st_q.pos;
    assign pos_ok_o   = st_q.pos_ok;
    assign inten_o    = st_q.inten;
    assign phase_o    = st_q.phs;
    assign wave_vld_o = st_q.wv;
    assign wave_a_o   = st_q.wa;
    assign wave_b_o   = st_q.wb;

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: results move only together with the completion pulse
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(pos_o) && $stable(inten_o) && $stable(phase_o) && $stable(pos_ok_o)));

    // R3: no streamed sample without the enable
    p_wave_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_en_i |=> !wave_vld_o);

    // R6: an invalid position reads as zero
    p_inv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pos_ok_o) |-> (pos_o == '0));
endmodule

// File: tb/tb_pulse_pos_phase_avg.sv
module tb_pulse_pos_phase_avg;
    localparam int DW   = 8;
    localparam int CW   = 6;
    localparam int FRAC = 10;
    localparam real PI  = 3.14159265358979;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, win, vld, wen;
    logic signed [DW-1:0] are, aim, bre, bim, rre, rim;
    logic done;
    logic signed [FRAC+1:0] pos;
    logic pos_ok;
    logic [DW+1:0] inten;
    logic [15:0] phase;
    logic wvld;
    logic [DW:0] wa, wb;

    int errors = 0;
    int checks = 0;

    pulse_pos_phase_avg #(.DW(DW), .CW(CW), .FRAC(FRAC)) dut (
        .clk(clk), .rst_n(rst_n), .win_i(win), .smp_vld_i(vld), .wave_en_i(wen),
        .a_re_i(are), .a_im_i(aim), .b_re_i(bre), .b_im_i(bim),
        .r_re_i(rre), .r_im_i(rim),
        .done_o(done), .pos_o(pos), .pos_ok_o(pos_ok), .inten_o(inten),
        .phase_o(phase), .wave_vld_o(wvld), .wave_a_o(wa), .wave_b_o(wb)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint magm(input int i, input int q);
        int ai, aq, hi, lo;
        ai = (i < 0) ? -i : i;
        aq = (q < 0) ? -q : q;
        hi = (ai >= aq) ? ai : aq;
        lo = (ai >= aq) ? aq : ai;
        return longint'(hi + lo / 2);
    endfunction

    // mode 0 pseudo-random, 1 zero plates, 2 angle sweep, 3 magnitude grid
    // gaps 0 none, 1 every third strobe low, 2 all strobes low
    task automatic run_pulse(input int n, input int seed, input bit we, input int gaps, input int mode);
        longint sa = 0, sb = 0, cnt = 0, xs = 0, ys = 0;
        bit pend = 0;
        longint pa = 0, pb = 0;
        longint tot, q, ep, ei;
        int ar, ai, br, bi, rr, ri;
        real th, e, hyp;
        logic signed [FRAC+1:0] hp;
        logic [DW+1:0] hi_;
        logic [15:0] hph;
        bit got;
        wen = we;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pend) begin
                chk(wvld == 1'b1, "R2 valid", longint'(wvld), 1);
                chk(longint'(wa) == pa, "R2 plate A", longint'(wa), pa);
                chk(longint'(wb) == pb, "R2 plate B", longint'(wb), pb);
            end else if (k > 0) begin
                chk(wvld == 1'b0, we ? "R9 no stream" : "R3 stream off", longint'(wvld), 0);
            end
            case (mode)
                1: begin ar = 0; ai = 0; br = 0; bi = 0; rr = 100; ri = 0; end
                2: begin
                    th = real'(seed) * 2.0 * PI / 16.0 + 0.1;
                    ar = $rtoi(100.0 * $cos(th)); ai = $rtoi(100.0 * $sin(th));
                    br = $rtoi(60.0 * $cos(th));  bi = $rtoi(60.0 * $sin(th));
                    rr = 110; ri = 0;
                end
                3: begin
                    int j;
                    j  = (seed * 50 + k) % 4096;
                    ar = (j % 64) * 4 - 128; ai = (j / 64) * 4 - 128;
                    br = ai; bi = ar; rr = 50; ri = -30;
                end
                default: begin
                    ar = ((seed * 53 + k * 29 + 7) % 256) - 128;
                    ai = ((seed * 17 + k * 71 + 3) % 256) - 128;
                    br = ((seed * 91 + k * 13 + 5) % 256) - 128;
                    bi = ((seed * 7 + k * 47 + 11) % 256) - 128;
                    rr = 100 + (seed % 20); ri = (seed * 3) % 40 - 20;
                end
            endcase
            are = DW'(ar); aim = DW'(ai); bre = DW'(br); bim = DW'(bi);
            rre = DW'(rr); rim = DW'(ri);
            win = 1'b1;
            vld = !((gaps == 2) || (gaps == 1 && (k % 3) == 1));
            pend = vld && we;
            if (vld) begin
                pa = magm(ar, ai); pb = magm(br, bi);
                sa += pa; sb += pb; cnt++;
                xs += longint'(ar + br) * rr + longint'(ai + bi) * ri;
                ys += longint'(ai + bi) * rr - longint'(ar + br) * ri;
            end
        end
        @(negedge clk);
        if (pend) begin
            chk(wvld == 1'b1, "R2 valid", longint'(wvld), 1);
            chk(longint'(wa) == pa, "R2 plate A", longint'(wa), pa);
        end
        win = 1'b0; vld = 1'b0;
        got = 0;
        for (int c = 0; c < 400 && !got; c++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        chk(got, "R8 done seen", longint'(got), 1);
        tot = sa + sb;
        ei = (cnt == 0) ? 0 : tot / cnt;
        chk(longint'(inten) == ei, (gaps != 0) ? "R9 intensity with gaps" : "R4 intensity", longint'(inten), ei);
        chk(pos_ok == (tot != 0), "R6 valid flag", longint'(pos_ok), longint'(tot != 0));
        if (tot != 0) begin
            q  = ((sa > sb ? sa - sb : sb - sa) << FRAC) / tot;
            ep = (sa < sb) ? -q : q;
            chk(longint'(pos) == ep, "R5 position", longint'(pos), ep);
        end else begin
            chk(pos == '0, "R6 position zero", longint'(pos), 0);
        end
        hyp = $sqrt(real'(xs) * real'(xs) + real'(ys) * real'(ys));
        if (hyp > 2000.0) begin
            int ex, d0;
            e  = $atan2(real'(ys), real'(xs)) * 65536.0 / (2.0 * PI);
            ex = $rtoi(e + ((e >= 0.0) ? 0.5 : -0.5));
            d0 = (int'(phase) - ex + 65536 * 4 + 32768) % 65536 - 32768;
            chk(d0 <= 12 && d0 >= -12, "R7 phase", longint'(phase), longint'((ex + 65536) % 65536));
        end
        hp = pos; hi_ = inten; hph = phase;
        @(negedge clk);
        chk(done == 1'b0, "R8 single pulse", longint'(done), 0);
        repeat (5) @(negedge clk);
        chk(pos == hp && inten == hi_ && phase == hph, "R8 held", longint'(phase), longint'(hph));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; win = 1'b0; vld = 1'b0; wen = 1'b0;
        are = '0; aim = '0; bre = '0; bim = '0; rre = '0; rim = '0;
        repeat (3) @(negedge clk);
        chk(done == 0 && wvld == 0 && pos_ok == 0, "R1 flags in reset", longint'({done, wvld, pos_ok}), 0);
        chk(pos == 0 && inten == 0 && phase == 0, "R1 values in reset", longint'(phase), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && wvld == 0 && pos == 0 && inten == 0, "R1 after release", longint'(done), 0);

        for (int s = 0; s < 12; s++) run_pulse(8 + s * 4, s, s % 2, (s % 3 == 2) ? 1 : 0, 0);
        for (int s = 0; s < 16; s++) run_pulse(20, s, 1'b1, 0, 2);
        run_pulse(10, 0, 1'b0, 0, 1);
        run_pulse(6, 3, 1'b1, 2, 0);
        for (int w = 0; w < 82; w++) run_pulse(50, w, 1'b1, 0, 3);
        run_pulse(30, 5, 1'b0, 1, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule